// File: doc/BRIEF.md
# Byte-Lane Permutation Crossbar with Two-Pass Merge

This block rearranges a wide vector one byte lane at a time. Each output lane owns a selector that picks any input lane, so a single operation can permute, shuffle or broadcast the whole vector. The result lands in an output register one clock edge after the operation is accepted. Selectors can address single bytes or whole elements of 2, 4 or 8 bytes. In the element sizes, an element index becomes a run of consecutive byte picks, so the bytes inside each element keep their order.

A merge mode builds one result from two source vectors without a wider multiplexer. The same lane multiplexers are used on two consecutive cycles. The first source is presented with the request and the second source on the following cycle. A source flag in each selector says which of the two passes fills that lane. Per-lane enables keep unused lanes still, and a disabled lane keeps its old value.

Top module: `vperm_xbar_top`

## Requirements
- R1: After synchronous reset, `out_data` is all zero and `out_valid` and `busy` are low.
- R2: In single mode (`in_accum`=0) with `in_esize`=0, output lane i takes source lane `in_sel[i*6 +: 5]` of `src_data` at the edge that accepts the request, and `out_valid` is high for the following cycle.
- R3: When every enabled selector names the same lane or element, that value is replicated across the output (broadcast).
- R4: With `in_esize` 1, 2 or 3 (elements of 2, 4 or 8 bytes), the selector in the lowest lane of each output element holds an element index k. Output byte b of that element takes source lane k*size+b, modulo the lane count. The selectors of the other lanes in the element are ignored.
- R5: An output lane whose `in_en` bit is low keeps its previous value.
- R6: In single mode the source flag `in_sel[i*6+5]` has no effect on the result.
- R7: In merge mode, the accept edge writes the enabled lanes whose source flag is 0 from the first source. The next edge writes the enabled lanes whose flag is 1 from `src_data` of that second cycle. `out_valid` is high only after the second edge.
- R8: `busy` is high for exactly the one cycle after a merge request is accepted. A request presented while `busy` is high is ignored: it changes no lane beyond the merge and produces no extra `out_valid`.
- R9: Single-mode requests are accepted on consecutive cycles, one result per cycle.
- R10: With no request and not busy, `out_data` holds and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_accum | input | 1 | 1 selects two-pass merge mode |
| in_esize | input | 2 | Element size: 0=1 byte, 1=2, 2=4, 3=8 bytes |
| in_sel | input | 192 | Six-bit selector per output lane: bit 5 source flag, bits 4:0 index |
| in_en | input | 32 | Per-output-lane enable |
| src_data | input | 256 | Source vector (second source during the busy cycle) |
| busy | output | 1 | Second merge pass in progress; new requests ignored |
| out_valid | output | 1 | Result complete in out_data |
| out_data | output | 256 | Registered result vector |

## Verification
The hardest case to reach is a request that arrives during the second merge pass. It must be dropped, while the same cycle's `src_data` still feeds the flagged lanes. The bench raises `in_valid` in the busy cycle with conflicting selectors and full enables. It then checks that only the merge's flagged lanes changed, and that the following idle cycle shows no `out_valid` and an unchanged vector.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int unsigned DEF_LANES  = 32;
    localparam int unsigned DEF_LANE_W = 8;

    typedef enum logic [1:0] {
        ES_B8  = 2'd0,
        ES_B16 = 2'd1,
        ES_B32 = 2'd2,
        ES_B64 = 2'd3
    } esize_e;

    // source lane for output lane 'lane' given an element index 'head'
    function automatic int unsigned src_lane(input int unsigned head,
                                             input int unsigned lane,
                                             input int unsigned shift,
                                             input int unsigned lanes);
        int unsigned span;
        span = 32'd1 << shift;
        return ((head << shift) + (lane % span)) % lanes;
    endfunction

endpackage

// File: rtl/vperm_expand.sv
module vperm_expand
    import vperm_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    localparam int unsigned IDX_W = $clog2(LANES),
    localparam int unsigned SEL_W = IDX_W + 1
) (
    input  logic [LANES*SEL_W-1:0] sel_in,
    input  esize_e                 esize,
    output logic [LANES*SEL_W-1:0] sel_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0] head;
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] mask;
        always_comb begin
            mask = IDX_W'((32'd1 << int'(esize)) - 32'd1);
            base = IDX_W'(i) & ~mask;
            head = sel_in[base*SEL_W +: SEL_W];
            sel_out[i*SEL_W +: SEL_W] = {head[SEL_W-1],
                IDX_W'(src_lane(int'(head[IDX_W-1:0]), i, int'(esize), LANES))};
        end
    end

endmodule

// File: rtl/vperm_ctrl.sv
module vperm_ctrl #(
    parameter int unsigned LANES = 32,
    parameter int unsigned SEL_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_accum,
    input  logic [LANES*SEL_W-1:0] live_sel,
    input  logic [LANES-1:0]       live_en,
    output logic                   phase,
    output logic                   act_accum,
    output logic [LANES*SEL_W-1:0] act_sel,
    output logic [LANES-1:0]       act_en,
    output logic                   out_valid
);

    logic                   phase_q;
    logic                   valid_q;
    logic [LANES*SEL_W-1:0] sel_q;
    logic [LANES-1:0]       en_q;
    logic                   accept;

    assign accept = in_valid & ~phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            valid_q <= 1'b0;
            sel_q   <= '0;
            en_q    <= '0;
        end else begin
            phase_q <= accept & in_accum;
            valid_q <= (accept & ~in_accum) | phase_q;
            if (accept & in_accum) begin
                sel_q <= live_sel;
                en_q  <= live_en;
            end
        end
    end

    always_comb begin
        phase     = phase_q;
        act_accum = phase_q | in_accum;
        act_sel   = phase_q ? sel_q : live_sel;
        act_en    = phase_q ? en_q : (accept ? live_en : '0);
        out_valid = valid_q;
    end

endmodule

// File: rtl/vperm_xbar.sv
module vperm_xbar #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned IDX_W = $clog2(LANES),
    localparam int unsigned SEL_W = IDX_W + 1
) (
    input  logic [LANES*LANE_W-1:0] data_in,
    input  logic [LANES*SEL_W-1:0]  sel,
    input  logic [LANES-1:0]        gate,
    output logic [LANES*LANE_W-1:0] data_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_mux
        logic [IDX_W-1:0] idx;
        assign idx = sel[i*SEL_W +: IDX_W];
        // a gated lane drives constant zero so its mux output stays quiet
        assign data_out[i*LANE_W +: LANE_W] =
            data_in[idx*LANE_W +: LANE_W] & {LANE_W{gate[i]}};
    end

endmodule

// File: rtl/vperm_xbar_top.sv
module vperm_xbar_top
    import vperm_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned LANE_W = DEF_LANE_W,
    localparam int unsigned IDX_W = $clog2(LANES),
    localparam int unsigned SEL_W = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_accum,
    input  logic [1:0]              in_esize,
    input  logic [LANES*SEL_W-1:0]  in_sel,
    input  logic [LANES-1:0]        in_en,
    input  logic [LANES*LANE_W-1:0] src_data,
    output logic                    busy,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_data
);

    logic [LANES*SEL_W-1:0]  live_sel;
    logic [LANES*SEL_W-1:0]  act_sel;
    logic [LANES-1:0]        act_en;
    logic [LANES-1:0]        wr;
    logic                    phase;
    logic                    act_accum;
    logic [LANES*LANE_W-1:0] mux_out;
    logic [LANES*LANE_W-1:0] out_q;

    vperm_expand #(.LANES(LANES)) u_expand (
        .sel_in  (in_sel),
        .esize   (esize_e'(in_esize)),
        .sel_out (live_sel)
    );

    vperm_ctrl #(.LANES(LANES), .SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_accum  (in_accum),
        .live_sel  (live_sel),
        .live_en   (in_en),
        .phase     (phase),
        .act_accum (act_accum),
        .act_sel   (act_sel),
        .act_en    (act_en),
        .out_valid (out_valid)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_wr
        assign wr[i] = act_en[i] &
                       (~act_accum | (act_sel[i*SEL_W + IDX_W] == phase));
    end

    vperm_xbar #(.LANES(LANES), .LANE_W(LANE_W)) u_xbar (
        .data_in  (src_data),
        .sel      (act_sel),
        .gate     (wr),
        .data_out (mux_out)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                out_q[i*LANE_W +: LANE_W] <= '0;
            else if (wr[i])
                out_q[i*LANE_W +: LANE_W] <= mux_out[i*LANE_W +: LANE_W];
        end
    end

    assign out_data = out_q;
    assign busy     = phase;

endmodule

// File: rtl/vperm_chk.sv
module vperm_chk #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_accum,
    input logic [LANES-1:0]        in_en,
    input logic                    busy,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_data
);

    a_r8_busy_after_merge: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && in_accum) |=> busy);

    a_r8_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    a_r7_valid_after_pass2: assert property (@(posedge clk) disable iff (rst)
        busy |=> out_valid);

    a_r7_no_valid_pass1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && in_accum) |=> !out_valid);

    a_r2_single_valid: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && !in_accum) |=> out_valid);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !busy) |=> ($stable(out_data) && !out_valid));

    a_r5_all_off_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && !in_accum && in_en == '0) |=> $stable(out_data));

endmodule

bind vperm_xbar_top vperm_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_accum  (in_accum),
    .in_en     (in_en),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/vperm_xbar_top_tb.sv
module vperm_xbar_top_tb;

    localparam int L = 32;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic           in_accum;
    logic [1:0]     in_esize;
    logic [L*6-1:0] in_sel;
    logic [L-1:0]   in_en;
    logic [L*8-1:0] src_data;
    logic           busy;
    logic           out_valid;
    logic [L*8-1:0] out_data;

    logic [L*8-1:0] exp_d;
    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    vperm_xbar_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_accum(in_accum),
        .in_esize(in_esize), .in_sel(in_sel), .in_en(in_en),
        .src_data(src_data), .busy(busy), .out_valid(out_valid),
        .out_data(out_data)
    );

    function automatic logic [L*8-1:0] pat(input int seed);
        logic [L*8-1:0] r;
        for (int i = 0; i < L; i++) r[i*8 +: 8] = 8'(i * 7 + seed * 13 + 1);
        return r;
    endfunction

    function automatic logic [L*8-1:0] model(input logic [L*8-1:0] cur,
        input logic [L*8-1:0] d, input logic [L*6-1:0] s, input logic [L-1:0] en,
        input int es, input bit acc, input bit pass);
        logic [L*8-1:0] r;
        r = cur;
        for (int i = 0; i < L; i++) begin
            int e;
            int base;
            int idx;
            logic [5:0] f;
            e    = 1 << es;
            base = i - (i % e);
            f    = s[base*6 +: 6];
            idx  = (int'(f[4:0]) * e + (i % e)) % L;
            if (en[i] && (!acc || f[5] == pass)) r[i*8 +: 8] = d[idx*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [L*8-1:0] ed,
                       input logic ev, input logic eb);
        n_chk++;
        if (out_data !== ed || out_valid !== ev || busy !== eb) begin
            n_bad++;
            $display("FAIL %s: data=%h valid=%b busy=%b expected data=%h valid=%b busy=%b",
                     req, out_data, out_valid, busy, ed, ev, eb);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_accum = 1'b0; in_esize = 2'd0;
        in_sel = '0; in_en = '0; src_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_d = '0;
        chk("R1 reset state", exp_d, 1'b0, 1'b0);
    endtask

    // one single-mode request; leaves in_valid high so calls run back to back
    task automatic t_single(input string req, input logic [L*8-1:0] d,
                            input logic [L*6-1:0] s, input logic [L-1:0] en, input int es);
        in_valid = 1'b1; in_accum = 1'b0; in_esize = 2'(es);
        in_sel = s; in_en = en; src_data = d;
        @(posedge clk);
        @(negedge clk);
        exp_d = model(exp_d, d, s, en, es, 1'b0, 1'b0);
        chk(req, exp_d, 1'b1, 1'b0);
    endtask

    task automatic t_idle(input string req);
        in_valid = 1'b0; src_data = pat(99); in_sel = '1;
        @(posedge clk);
        @(negedge clk);
        chk(req, exp_d, 1'b0, 1'b0);
    endtask

    task automatic t_merge(input string req, input logic [L*8-1:0] d0,
                           input logic [L*8-1:0] d1, input logic [L*6-1:0] s,
                           input logic [L-1:0] en, input int es, input bit intrude);
        in_valid = 1'b1; in_accum = 1'b1; in_esize = 2'(es);
        in_sel = s; in_en = en; src_data = d0;
        @(posedge clk);
        @(negedge clk);
        exp_d = model(exp_d, d0, s, en, es, 1'b1, 1'b0);
        chk({req, " pass 1"}, exp_d, 1'b0, 1'b1);
        src_data = d1;
        if (intrude) begin
            in_valid = 1'b1; in_accum = 1'b0; in_esize = 2'd0;
            in_en = '1;
            for (int i = 0; i < L; i++) in_sel[i*6 +: 6] = 6'(3);
        end else begin
            in_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        exp_d = model(exp_d, d1, s, en, es, 1'b1, 1'b1);
        chk({req, " pass 2"}, exp_d, 1'b1, 1'b0);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [L*6-1:0] s;
        t_reset();

        for (int i = 0; i < L; i++) s[i*6 +: 6] = 6'(L - 1 - i);
        t_single("R2 reverse", pat(1), s, '1, 0);
        for (int i = 0; i < L; i++) s[i*6 +: 6] = 6'((i + 5) % L);
        t_single("R9 rotate back-to-back", pat(2), s, '1, 0);
        for (int i = 0; i < L; i++) s[i*6 +: 6] = 6'(7);
        t_single("R3 byte broadcast", pat(3), s, '1, 0);
        t_idle("R10 idle hold");

        for (int i = 0; i < L; i++) s[i*6 +: 6] = (i % 2 == 0) ? 6'(15 - i / 2) : 6'(0);
        t_single("R4 16-bit reverse", pat(4), s, '1, 1);
        for (int i = 0; i < L; i++) s[i*6 +: 6] = (i % 4 == 0) ? 6'((i / 4 + 3) % 8) : 6'(i);
        t_single("R4 32-bit rotate", pat(5), s, '1, 2);
        for (int i = 0; i < L; i++) s[i*6 +: 6] = 6'(2);
        t_single("R3 64-bit broadcast", pat(6), s, '1, 3);
        for (int i = 0; i < L; i++) s[i*6 +: 6] = (i % 8 == 0) ? 6'(3 - i / 8) : 6'(1);
        t_single("R4 64-bit reverse", pat(7), s, '1, 3);

        for (int i = 0; i < L; i++) s[i*6 +: 6] = 6'(i);
        t_single("R5 half enabled", pat(8), s, 32'h0F0F_00FF, 0);
        t_single("R5 none enabled", pat(9), s, '0, 0);
        for (int i = 0; i < L; i++) s[i*6 +: 6] = {1'b1, 5'((i * 3) % L)};
        t_single("R6 flag ignored in single mode", pat(10), s, '1, 0);
        t_idle("R10 idle after singles");

        for (int i = 0; i < L; i++) s[i*6 +: 6] = {1'(i % 2), 5'(i / 2)};
        t_merge("R7 interleave merge", pat(11), pat(12), s, '1, 0, 1'b0);
        t_idle("R10 idle after merge");
        for (int i = 0; i < L; i++) s[i*6 +: 6] = {1'(i >= 16), 5'(L - 1 - i)};
        t_merge("R8 merge with blocked request", pat(13), pat(14), s, 32'hFFFF_7FFE, 0, 1'b1);
        t_idle("R8 no extra result");
        for (int i = 0; i < L; i++) s[i*6 +: 6] = {1'((i / 4) % 2), 5'(i / 8)};
        t_merge("R7 32-bit element merge", pat(15), pat(16), s, '1, 2, 1'b0);
        t_single("R9 single right after merge", pat(17), s, '1, 0);
        t_idle("R10 final idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule